// File: doc/BRIEF.md
# Column Redundancy Shift Steering

This block sits between the user-side data ports of a memory and a physical storage array that has exactly one column more than the logical word. When a column of the array is known to be broken, the block steers data around it. The broken column's position and a repair-enable flag are captured once after power-up from non-volatile repair storage, through a load strobe. With repair active, every logical bit from the broken column upward is written one physical column higher, so the topmost logical bit lands in the spare column and the broken column is never written. On the read side the opposite steering rebuilds the logical word, so the user sees the data it wrote.

The write data and the per-bit write mask are steered by the same shift, so that partial writes still reach the right physical columns. With repair off, the mapping is one to one and the spare column receives neither data nor a write enable. Both steering paths are purely combinational. Only the repair configuration is held in a register.

Top module: `colrep_steer`

## Requirements
- R1: While reset is asserted, and right after it, repair is off: the mapping is one to one and the spare column (physical bit DATA_W) has data 0 and mask 0.
- R2: The enable flag and the broken-column index are captured at a rising clock edge on which `cfg_load` is high, and they take effect from that edge. At all other edges, changes on `cfg_enable` and `cfg_fail_idx` have no effect on the mapping.
- R3: With repair off, `phy_wr_data[j] = wr_data[j]` and `phy_wr_mask[j] = wr_mask[j]` for j < DATA_W, spare data and mask are 0, and `rd_data[i] = phy_rd_data[i]`.
- R4: With repair on and broken index k, `phy_wr_data[j] = wr_data[j]` for j < k, `phy_wr_data[j] = wr_data[j-1]` for k < j <= DATA_W, and `phy_wr_data[k] = 0`.
- R5: The write mask is steered exactly like the data, and the mask bit of the broken column is 0, so the number of set physical mask bits equals the number of set logical mask bits.
- R6: With repair on and broken index k, `rd_data[i] = phy_rd_data[i]` for i < k and `rd_data[i] = phy_rd_data[i+1]` for i >= k. The value read from column k never reaches `rd_data`, so a stuck column still returns the written word.
- R7: A broken index of DATA_W-1 moves only the top logical bit, into the spare column. All lower bits keep their columns.
- R8: A broken index of 0 moves every logical bit up by one column, and physical column 0 is left unwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Strobe that captures the repair configuration |
| cfg_enable | input | 1 | Repair-enable value to capture |
| cfg_fail_idx | input | IDX_W | Index of the broken physical column to capture |
| wr_data | input | DATA_W | Logical write data |
| wr_mask | input | DATA_W | Logical per-bit write enable, 1 = write |
| phy_wr_data | output | DATA_W+1 | Steered write data to the physical array |
| phy_wr_mask | output | DATA_W+1 | Steered per-bit write enable to the physical array |
| phy_rd_data | input | DATA_W+1 | Raw read data from the physical array |
| rd_data | output | DATA_W | Rebuilt logical read data |

## Verification
On every cycle the assertions check that the configuration holds between load strobes, that the direct mapping leaves the spare column idle, that the broken column never receives data or a write enable, that the top logical bit sits in the spare column with the mask population preserved, and that the top read bit comes from the spare column. What only the bench's scenarios can show is the full bit-by-bit placement for each index, including both edge indices. The bench also checks a write and read round trip through a modelled array with a stuck column, and that the configuration inputs are ignored when the strobe is low.

// File: rtl/colrep_pkg.sv
package colrep_pkg;

   typedef enum logic [0:0] {
      MAP_DIRECT  = 1'b0,
      MAP_SHIFTED = 1'b1
   } map_mode_e;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/colrep_cfg_reg.sv
module colrep_cfg_reg
   import colrep_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned IDX_W  = idx_bits(DATA_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             enable_i,
   input  logic [IDX_W-1:0] idx_i,
   output map_mode_e        mode_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [IDX_W:0] IDX_LIMIT = (IDX_W+1)'(DATA_W);

   logic in_range;
   assign in_range = ({1'b0, idx_i} < IDX_LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o <= MAP_DIRECT;
         idx_o  <= '0;
      end else if (load_i) begin
         mode_o <= (enable_i && in_range) ? MAP_SHIFTED : MAP_DIRECT;
         idx_o  <= in_range ? idx_i : '0;
      end
   end

endmodule

// File: rtl/colrep_wr_shift.sv
module colrep_wr_shift #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned IDX_W  = 4
) (
   input  logic              shifted_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] in_i,
   output logic [DATA_W:0]   out_o
);

   for (genvar j = 0; j <= DATA_W; j++) begin : g_col
      if (j == DATA_W) begin : g_spare
         assign out_o[j] = shifted_i ? in_i[DATA_W-1] : 1'b0;
      end else if (j == 0) begin : g_bottom
         assign out_o[j] = (shifted_i && (idx_i == '0)) ? 1'b0 : in_i[0];
      end else begin : g_mid
         localparam logic [IDX_W-1:0] COL = IDX_W'(j);
         always_comb begin
            if (!shifted_i || (COL < idx_i)) begin
               out_o[j] = in_i[j];
            end else if (COL == idx_i) begin
               out_o[j] = 1'b0;
            end else begin
               out_o[j] = in_i[j-1];
            end
         end
      end
   end

endmodule

// File: rtl/colrep_rd_unshift.sv
module colrep_rd_unshift #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned IDX_W  = 4
) (
   input  logic              shifted_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W:0]   phy_i,
   output logic [DATA_W-1:0] out_o
);

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam logic [IDX_W-1:0] POS = IDX_W'(i);
      assign out_o[i] = (shifted_i && (POS >= idx_i)) ? phy_i[i+1] : phy_i[i];
   end

endmodule

// File: rtl/colrep_steer.sv
module colrep_steer
   import colrep_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned IDX_W  = idx_bits(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic              cfg_enable,
   input  logic [IDX_W-1:0]  cfg_fail_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] wr_mask,
   output logic [DATA_W:0]   phy_wr_data,
   output logic [DATA_W:0]   phy_wr_mask,
   input  logic [DATA_W:0]   phy_rd_data,
   output logic [DATA_W-1:0] rd_data
);

   localparam int unsigned PHY_W = DATA_W + 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("colrep_steer: DATA_W must be at least 2");
   end
   if ((1 << IDX_W) < DATA_W) begin : g_bad_idx
      $error("colrep_steer: IDX_W too narrow for DATA_W");
   end
   if (PHY_W != DATA_W + 1) begin : g_bad_phy
      $error("colrep_steer: physical width must be one more than DATA_W");
   end

   map_mode_e        rep_mode;
   logic [IDX_W-1:0] rep_idx;
   logic             rep_shifted;

   colrep_cfg_reg #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (cfg_load),
      .enable_i (cfg_enable),
      .idx_i    (cfg_fail_idx),
      .mode_o   (rep_mode),
      .idx_o    (rep_idx)
   );

   assign rep_shifted = (rep_mode == MAP_SHIFTED);

   colrep_wr_shift #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_data_shift (
      .shifted_i (rep_shifted),
      .idx_i     (rep_idx),
      .in_i      (wr_data),
      .out_o     (phy_wr_data)
   );

   colrep_wr_shift #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_mask_shift (
      .shifted_i (rep_shifted),
      .idx_i     (rep_idx),
      .in_i      (wr_mask),
      .out_o     (phy_wr_mask)
   );

   colrep_rd_unshift #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_rd_unshift (
      .shifted_i (rep_shifted),
      .idx_i     (rep_idx),
      .phy_i     (phy_rd_data),
      .out_o     (rd_data)
   );

endmodule

// File: rtl/colrep_steer_chk.sv
module colrep_steer_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned IDX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_load,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] wr_mask,
   input logic [DATA_W:0]   phy_wr_data,
   input logic [DATA_W:0]   phy_wr_mask,
   input logic [DATA_W:0]   phy_rd_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              rep_shifted,
   input logic [IDX_W-1:0]  rep_idx
);

   assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> ($stable(rep_shifted) && $stable(rep_idx)));

   assert_direct_spare_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rep_shifted |-> (phy_wr_data[DATA_W] == 1'b0 && phy_wr_mask[DATA_W] == 1'b0
                        && rd_data == phy_rd_data[DATA_W-1:0]));

   assert_spare_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rep_shifted |-> (phy_wr_data[DATA_W] == wr_data[DATA_W-1]
                       && phy_wr_mask[DATA_W] == wr_mask[DATA_W-1]));

   assert_dead_col_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rep_shifted |-> (phy_wr_mask[rep_idx] == 1'b0 && phy_wr_data[rep_idx] == 1'b0));

   assert_mask_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(phy_wr_mask) == $countones(wr_mask));

   assert_rd_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rep_shifted |-> (rd_data[DATA_W-1] == phy_rd_data[DATA_W]));

endmodule

bind colrep_steer colrep_steer_chk #(
   .DATA_W (DATA_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_load    (cfg_load),
   .wr_data     (wr_data),
   .wr_mask     (wr_mask),
   .phy_wr_data (phy_wr_data),
   .phy_wr_mask (phy_wr_mask),
   .phy_rd_data (phy_rd_data),
   .rd_data     (rd_data),
   .rep_shifted (rep_shifted),
   .rep_idx     (rep_idx)
);

// File: tb/colrep_steer_bench.sv
module colrep_steer_bench;

   localparam int DW = 16;
   localparam int IW = 4;

   typedef struct packed {
      logic          en;
      logic [IW-1:0] idx;
      logic [DW-1:0] d;
      logic [DW-1:0] m;
      logic [DW:0]   prd;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 4'd0,  16'hA5C3, 16'hFFFF, 17'h1_2345},
      '{1'b1, 4'd5,  16'hA5C3, 16'hFFFF, 17'h0_F0F1},
      '{1'b1, 4'd0,  16'h1234, 16'h00FF, 17'h1_ABCD},
      '{1'b1, 4'd15, 16'hFFFF, 16'hF00F, 17'h0_7777},
      '{1'b1, 4'd8,  16'h8001, 16'h5555, 17'h1_0001},
      '{1'b1, 4'd3,  16'h0F0F, 16'hAAAA, 17'h0_3C3C},
      '{1'b0, 4'd7,  16'hDEAD, 16'h0F0F, 17'h1_BEEF},
      '{1'b1, 4'd12, 16'hCAFE, 16'hFFFF, 17'h1_FFFF},
      '{1'b1, 4'd1,  16'h0002, 16'h0003, 17'h0_0006},
      '{1'b1, 4'd14, 16'h4000, 16'hC000, 17'h1_8000}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_load = 1'b0;
   logic          cfg_enable = 1'b0;
   logic [IW-1:0] cfg_fail_idx = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] wr_mask = '0;
   logic [DW:0]   phy_wr_data;
   logic [DW:0]   phy_wr_mask;
   logic [DW:0]   phy_rd_data = '0;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   colrep_steer #(.DATA_W(DW), .IDX_W(IW)) u_colrep_steer (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_load     (cfg_load),
      .cfg_enable   (cfg_enable),
      .cfg_fail_idx (cfg_fail_idx),
      .wr_data      (wr_data),
      .wr_mask      (wr_mask),
      .phy_wr_data  (phy_wr_data),
      .phy_wr_mask  (phy_wr_mask),
      .phy_rd_data  (phy_rd_data),
      .rd_data      (rd_data)
   );

   // Placement model taken from R3/R4/R5: below k keep, at k zero, above k take bit below.
   function automatic logic [DW:0] exp_wr(input logic en, input int k, input logic [DW-1:0] v);
      logic [DW:0] r;
      r = '0;
      for (int j = 0; j <= DW; j++) begin
         if (!en) r[j] = (j < DW) ? v[j] : 1'b0;
         else if (j < k) r[j] = v[j];
         else if (j == k) r[j] = 1'b0;
         else r[j] = v[j-1];
      end
      return r;
   endfunction

   // Read model from R3/R6: skip column k.
   function automatic logic [DW-1:0] exp_rd(input logic en, input int k, input logic [DW:0] p);
      logic [DW-1:0] r;
      for (int i = 0; i < DW; i++) r[i] = (en && i >= k) ? p[i+1] : p[i];
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_cfg(input logic en, input logic [IW-1:0] k);
      @(negedge clk);
      cfg_load = 1'b1;
      cfg_enable = en;
      cfg_fail_idx = k;
      @(posedge clk);
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic apply(input logic [DW-1:0] d, input logic [DW-1:0] m, input logic [DW:0] p);
      wr_data = d;
      wr_mask = m;
      phy_rd_data = p;
      #1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [DW:0] stored;
      string tag;

      // R1: reset state, with config inputs active but no strobe
      cfg_enable = 1'b1;
      cfg_fail_idx = 4'd3;
      repeat (3) @(posedge clk);
      @(negedge clk);
      apply(16'hFFFF, 16'hFFFF, 17'h1_5555);
      check("R1 reset spare data", 32'(phy_wr_data[DW]), 32'h0);
      check("R1 reset spare mask", 32'(phy_wr_mask[DW]), 32'h0);
      check("R1 reset rd map", 32'(rd_data), 32'h5555);
      rst_n = 1'b1;
      @(negedge clk);
      apply(16'h8421, 16'hFFFF, 17'h1_8421);
      check("R1 after reset direct", 32'(phy_wr_data), 32'h0_8421);

      // Table walk
      for (int v = 0; v < NV; v++) begin
         load_cfg(TBL[v].en, TBL[v].idx);
         apply(TBL[v].d, TBL[v].m, TBL[v].prd);
         if (!TBL[v].en) tag = "R3";
         else if (TBL[v].idx == 4'd15) tag = "R7";
         else if (TBL[v].idx == 4'd0) tag = "R8";
         else tag = "R4";
         check({tag, " wr data"}, 32'(phy_wr_data),
               32'(exp_wr(TBL[v].en, int'(TBL[v].idx), TBL[v].d)));
         check("R5 wr mask", 32'(phy_wr_mask),
               32'(exp_wr(TBL[v].en, int'(TBL[v].idx), TBL[v].m)));
         check("R6 rd data", 32'(rd_data),
               32'(exp_rd(TBL[v].en, int'(TBL[v].idx), TBL[v].prd)));
      end

      // R7: only the top bit moves
      load_cfg(1'b1, 4'd15);
      apply(16'h8001, 16'hFFFF, '0);
      check("R7 top to spare", 32'(phy_wr_data), 32'h1_0001);
      check("R7 mask", 32'(phy_wr_mask), 32'h1_7FFF);

      // R8: everything moves
      load_cfg(1'b1, 4'd0);
      apply(16'h0001, 16'hFFFF, '0);
      check("R8 all shifted", 32'(phy_wr_data), 32'h0_0002);
      check("R8 mask", 32'(phy_wr_mask), 32'h1_FFFE);

      // R2: config inputs ignored without strobe
      load_cfg(1'b1, 4'd6);
      @(negedge clk);
      cfg_enable = 1'b0;
      cfg_fail_idx = 4'd2;
      repeat (3) @(negedge clk);
      apply(16'h0040, 16'h0000, '0);
      check("R2 ignored without load", 32'(phy_wr_data), 32'h0_0080);
      apply(16'h0004, 16'h0000, '0);
      check("R2 ignored low bit", 32'(phy_wr_data), 32'h0_0004);
      load_cfg(1'b0, 4'd6);
      apply(16'h0040, 16'h0000, '0);
      check("R2 load disables", 32'(phy_wr_data), 32'h0_0040);

      // R6/R5: round trip through an array with column k stuck at 1
      for (int k = 0; k < DW; k++) begin
         load_cfg(1'b1, 4'(k));
         apply(16'h3C5A ^ 16'(k * 16'h1111), 16'hFFFF, '0);
         stored = phy_wr_data | (17'h1 << k);
         check("R5 dead col mask", 32'(phy_wr_mask[k]), 32'h0);
         apply(wr_data, wr_mask, stored);
         check("R6 round trip stuck col", 32'(rd_data), 32'(wr_data));
      end

      // R1: reset mid-run returns to direct mapping
      @(negedge clk);
      rst_n = 1'b0;
      apply(16'h8000, 16'h8000, 17'h0_0001);
      check("R1 mid-run reset spare", 32'(phy_wr_data[DW]), 32'h0);
      check("R1 mid-run reset rd", 32'(rd_data), 32'h0001);
      rst_n = 1'b1;

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule